// File: doc/BRIEF.md
# Pulse-Swallow Programmable Frequency Divider

This block divides a VCO clock by a programmable ratio N = 32·M + S and emits one comparison pulse per N input cycles for a downstream phase detector. A 32/33 dual-modulus prescaler stage is steered by a 5-bit swallow counter S: for the first S prescaler cycles of each output period it counts 33 clocks, and for the rest it counts 32. An 11-bit main counter M counts the prescaler cycles in one period. Everything runs as synchronous logic on the VCO clock.

The M and S values come from a control latch and are sampled only when a period ends, so a new setting never disturbs the period in progress. An active-low run input puts the divider in standby and holds it in reset. A window flag marks the 64 VCO cycles centred on the falling edge of the comparison pulse, so that a window generator can tell whether a phase error falls close to that edge.

Top module: `psw_divider`

## Requirements
- R1: For any M in 32..2047 and S in 0..31, the comparison pulse `fv_o` repeats every 32·M + S VCO cycles, with no pulse in between.
- R2: `fv_o` is high for exactly one VCO cycle per period.
- R3: The ratio extremes hold: M=32,S=0 gives 1024 cycles; M=32,S=31 gives 1055; M=2047,S=31 gives 65535.
- R4: A change of `main_div` or `swallow_div` in the middle of a period leaves that period's length unchanged; the new ratio applies from the following period on.
- R5: While `run` is low, `fv_o` and `win_o` are low and the counters are held in reset; on the first VCO edge after `run` rises, `fv_o` pulses, and the next pulse follows after the ratio sampled at that edge.
- R6: `win_o` is high for the 31 cycles before each `fv_o` pulse, the pulse cycle itself and the 32 cycles after it (64 cycles centred on the falling edge of `fv_o`), and low otherwise once a full period has run.
- R7: The setting M=314, S=4 yields a period of 10052 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| vco_clk | input | 1 | VCO clock being divided |
| run | input | 1 | Active-low standby: low holds the divider in reset |
| main_div | input | 11 | Main counter value M (32..2047) |
| swallow_div | input | 5 | Swallow counter value S (0..31) |
| fv_o | output | 1 | One-cycle comparison pulse, once per N cycles |
| win_o | output | 1 | High during the 64 cycles around the falling edge of `fv_o` |

## Verification
The ratio is tried with S at zero (pure divide-by-32 prescaling, which exposes a wrong main count), with S at its maximum (every prescaler cycle but one at 33, which exposes a swallow count that runs one too long or too short), with the worked 314/4 setting and with random small legal pairs, plus the largest ratio. A setting changed 100 cycles into a period separates a divider that reloads only at the boundary from one that picks values up immediately. A standby pulse mid-period shows the counters restart rather than resume, and every measured period also checks the window edges cycle by cycle.

// File: rtl/psw_divider.sv
module psw_divider #(
  parameter int MW  = 11,
  parameter int SW  = 5,
  parameter int PSW = 5
) (
  input  logic          vco_clk,
  input  logic          run,
  input  logic [MW-1:0] main_div,
  input  logic [SW-1:0] swallow_div,
  output logic          fv_o,
  output logic          win_o
);
  localparam int PLEN = 1 << PSW;
  localparam int PCW  = PSW + 1;

  logic [PCW-1:0] pc;
  logic [SW-1:0]  s_rem;
  logic [MW-1:0]  m_rem;
  logic [PCW-1:0] post;
  logic           pre_q;
  logic           fv_q;

  wire swal       = s_rem != '0;
  wire last_main  = m_rem == MW'(1);
  wire pre_end    = pc == (swal ? PCW'(PLEN) : PCW'(PLEN - 1));
  wire period_end = pre_end && last_main;

  always_ff @(posedge vco_clk or negedge run) begin
    if (!run) begin
      pc    <= PCW'(PLEN - 1);
      s_rem <= '0;
      m_rem <= MW'(1);
      post  <= '0;
      pre_q <= 1'b0;
      fv_q  <= 1'b0;
    end else begin
      fv_q  <= period_end;
      pre_q <= last_main;
      if (fv_q)
        post <= PCW'(PLEN);
      else if (post != '0)
        post <= post - PCW'(1);
      if (pre_end) begin
        pc <= '0;
        if (last_main) begin
          m_rem <= main_div;
          s_rem <= swallow_div;
        end else begin
          m_rem <= m_rem - MW'(1);
          if (swal) s_rem <= s_rem - SW'(1);
        end
      end else begin
        pc <= pc + PCW'(1);
      end
    end
  end

  assign fv_o  = fv_q;
  assign win_o = pre_q | (post != '0);
endmodule

// File: rtl/psw_divider_chk.sv
module psw_divider_chk (
  input logic clk,
  input logic run,
  input logic fv,
  input logic win
);
  logic [16:0] gap;
  logic        seen;

  always_ff @(posedge clk or negedge run) begin
    if (!run) begin
      gap  <= 17'd1;
      seen <= 1'b0;
    end else if (fv) begin
      gap  <= 17'd1;
      seen <= 1'b1;
    end else if (gap != 17'h1ffff) begin
      gap  <= gap + 17'd1;
    end
  end

  a_r1_min_period: assert property (@(posedge clk) disable iff (!run)
    (fv && seen) |-> (gap >= 17'd1024));

  a_r2_fv_one_cycle: assert property (@(posedge clk) disable iff (!run)
    fv |=> !fv);

  a_r5_standby_quiet: assert property (@(posedge clk)
    !run |-> (!fv && !win));

  a_r6_win_covers_fv: assert property (@(posedge clk) disable iff (!run)
    fv |-> win);

  a_r6_win_after_fv: assert property (@(posedge clk) disable iff (!run)
    fv |=> win);
endmodule

bind psw_divider psw_divider_chk u_chk (
  .clk(vco_clk), .run(run), .fv(fv_o), .win(win_o)
);

// File: tb/psw_divider_tb.sv
module psw_divider_tb;
  logic        clk = 1'b0;
  logic        run = 1'b0;
  logic [10:0] m_in = 11'd40;
  logic [4:0]  s_in = 5'd7;
  logic        fv_o, win_o;
  int checks = 0, fails = 0;
  int cur_n = 0;

  always #5 clk = ~clk;

  psw_divider u_dut (
    .vco_clk(clk), .run(run), .main_div(m_in), .swallow_div(s_in),
    .fv_o(fv_o), .win_o(win_o)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic next_fv();
    @(negedge clk);
    while (fv_o !== 1'b1) @(negedge clk);
  endtask

  // called with the current sample showing fv_o high
  task automatic check_period(input int n, input string req);
    int fv_bad = 0, win_bad = 0, first_fv = 0;
    for (int i = 1; i <= n; i++) begin
      @(negedge clk);
      if (fv_o !== (i == n)) begin
        fv_bad++;
        if (first_fv == 0) first_fv = i;
      end
      if (win_o !== ((i <= 32) || (i >= n - 31))) win_bad++;
    end
    check(fv_bad == 0, req, "period (first stray fv index)", first_fv, n);
    check(win_bad == 0, "R6", "window mismatching cycles", win_bad, 0);
  endtask

  task automatic run_ratio(input int m, input int s, input string req);
    next_fv();
    m_in = 11'(m);
    s_in = 5'(s);
    next_fv();
    cur_n = 32 * m + s;
    check_period(cur_n, req);
  endtask

  task automatic t_midchange();
    int cnt = 0;
    next_fv();
    repeat (100) @(negedge clk);
    m_in = 11'd100;
    s_in = 5'd17;
    @(negedge clk);
    cnt = 101;
    while (fv_o !== 1'b1) begin
      @(negedge clk);
      cnt++;
    end
    check(cnt == cur_n, "R4", "period with mid change", cnt, cur_n);
    cur_n = 3217;
    check_period(cur_n, "R4");
  endtask

  task automatic t_standby();
    next_fv();
    repeat (200) @(negedge clk);
    run = 1'b0;
    m_in = 11'd50;
    s_in = 5'd9;
    repeat (3) @(negedge clk);
    check(fv_o === 1'b0, "R5", "fv in standby", fv_o, 0);
    check(win_o === 1'b0, "R5", "win in standby", win_o, 0);
    run = 1'b1;
    @(negedge clk);
    check(fv_o === 1'b1, "R5", "fv after release", fv_o, 1);
    cur_n = 1609;
    check_period(cur_n, "R5");
  endtask

  initial begin
    #1;
    check(fv_o === 1'b0, "R5", "fv in reset", fv_o, 0);
    check(win_o === 1'b0, "R5", "win in reset", win_o, 0);
    repeat (3) @(negedge clk);
    run = 1'b1;
    @(negedge clk);
    check(fv_o === 1'b1, "R5", "first fv after start", fv_o, 1);
    cur_n = 1287;
    check_period(cur_n, "R1");
    run_ratio(32, 0, "R3");
    run_ratio(32, 31, "R3");
    run_ratio(314, 4, "R7");
    t_midchange();
    for (int k = 0; k < 3; k++)
      run_ratio(int'($urandom_range(120, 32)), int'($urandom_range(31, 0)), "R1");
    t_standby();
    run_ratio(2047, 31, "R3");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (195000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule